// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit works on a bit field that lives in byte-addressed, big-endian memory. A command gives a base byte address, a signed bit offset measured from the most significant bit of that byte, and a 5-bit width code. The unit supports seven operations: unsigned extract, signed extract, insert, invert, clear, set and find-first-one. It works out the smallest naturally sized window that holds the field and reads it in one access of 1, 2, 4 or 8 bytes. It then isolates the field with a mask. For the modifying operations it writes the updated window back at the same address and with the same size.

Each command starts with a one-cycle `start` pulse while the unit is idle. It ends with a one-cycle `done` pulse. `result` then holds the operation's return value until the next command is accepted. A `start` that arrives while a command is in progress is ignored.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The field width is `width_code` when that code is 1 to 31, and 32 when the code is 0.
- R2: The field starts at byte `base_addr + floor(bit_ofs/8)`, at bit `bit_ofs mod 8` (0 to 7, counted from the byte's MSB). The access size is chosen from the number of extra bytes spanned, s = (bit + width - 1)/8: s=0 uses one byte, s=1 two bytes, s=2 or s=3 four bytes, and s=4 eight bytes. A four-byte access for s=2 at an odd byte address starts one byte lower. An eight-byte access starts at the byte address rounded down to a multiple of 4.
- R3: Memory port: `mem_size` 0/1/2/3 means 1/2/4/8 bytes. The byte at `mem_addr` is the most significant of the bytes used, and the data is right-justified in `mem_rdata`/`mem_wdata`. A request holds `mem_addr`, `mem_we` and `mem_size` stable until `mem_ack`.
- R4: Op 0 (unsigned extract) returns the field right-justified and zero-extended. Op 7 behaves the same.
- R5: Op 1 (signed extract) returns the field right-justified and sign-extended from its top bit.
- R6: Op 2 (insert) replaces the field with the low `width` bits of `src_val` and returns `src_val << (32 - width)`.
- R7: Ops 3, 4 and 5 (invert, clear, set) write the field inverted, all zeros or all ones. Each returns the old field left-justified in 32 bits, with zeros below it. No bit outside the field changes.
- R8: Op 6 (find first one) returns `bit_ofs` plus the index, counted from the field's top bit, of the first 1 bit. If the field is all zeros it returns `bit_ofs + width`. Memory is not written.
- R9: Ops 2 to 5 make exactly one read and then, in the very next request, one write with the same address and size. Ops 0, 1, 6 and 7 make one read and no write.
- R10: `done` is a single-cycle pulse. A `start` given while a command is in progress is ignored.
- R11: After reset, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | command strobe, taken only when idle |
| op | input | 3 | operation code |
| base_addr | input | AW | base byte address |
| bit_ofs | input | 32 | signed bit offset |
| width_code | input | 5 | field width, 0 meaning 32 |
| src_val | input | 32 | value to insert |
| done | output | 1 | command complete pulse |
| result | output | 32 | return value, valid from done until next start |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | request is a write |
| mem_addr | output | AW | access byte address |
| mem_size | output | 2 | access size code |
| mem_wdata | output | 64 | write data, right-justified |
| mem_rdata | input | 64 | read data, right-justified |
| mem_ack | input | 1 | request accepted and completed |

## Verification
The bench uses directed fields that place each span (one to five bytes) at both even and odd addresses. It adds negative offsets, so a wrong floor or a wrong window shift shows up as a different field. Width code 0 and widths close to 32 separate the 32-bit case from a truncated one. Fields with the top bit set and clear tell the signed extract apart from the unsigned one. A cleared field followed by find-first-one checks the all-zero return. Several hundred random commands are then scored against a bit-serial reference of the whole memory image, which catches any change to a bit outside the field.

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   bit_ofs,
  input  logic [4:0]    width_code,
  input  logic [31:0]   src_val,
  output logic          done,
  output logic [31:0]   result,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ack
);

  localparam int WIN = 64;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_t;
  st_t st;

  function automatic logic [5:0] lead0(input logic [31:0] x);
    lead0 = 6'd32;
    for (int i = 0; i < 32; i++)
      if (x[i]) lead0 = 6'(31 - i);
  endfunction

  function automatic logic writes(input logic [2:0] o);
    writes = (o >= 3'd2) && (o <= 3'd5);
  endfunction

  // command preparation
  logic [5:0]        len_in;
  logic signed [31:0] byte_step;
  logic [AW-1:0]     a0;
  logic [6:0]        span_sum;
  logic [2:0]        span;
  logic [AW-1:0]     p_addr;
  logic [5:0]        p_bofs;
  logic [1:0]        p_size;

  assign len_in    = (width_code == 5'd0) ? 6'd32 : {1'b0, width_code};
  assign byte_step = $signed(bit_ofs) >>> 3;
  assign a0        = base_addr + AW'(byte_step);
  assign span_sum  = {4'd0, bit_ofs[2:0]} + {1'b0, len_in} - 7'd1;
  assign span      = span_sum[5:3];

  always_comb begin
    p_addr = a0;
    p_bofs = {3'd0, bit_ofs[2:0]};
    p_size = 2'd2;
    case (span)
      3'd0: begin p_bofs = p_bofs + 6'd56; p_size = 2'd0; end
      3'd1: begin p_bofs = p_bofs + 6'd48; p_size = 2'd1; end
      3'd2: begin
        if (a0[0]) begin
          p_addr = a0 - AW'(1);
          p_bofs = p_bofs + 6'd40;
        end else begin
          p_bofs = p_bofs + 6'd32;
        end
      end
      3'd3: p_bofs = p_bofs + 6'd32;
      default: begin
        p_addr = {a0[AW-1:2], 2'b00};
        p_bofs = p_bofs + {1'b0, a0[1:0], 3'd0};
        p_size = 2'd3;
      end
    endcase
  end

  // command registers
  logic [2:0]     r_op;
  logic [5:0]     r_len;
  logic [5:0]     r_bofs;
  logic [31:0]    r_ofs;
  logic [31:0]    r_val;
  logic [AW-1:0]  r_addr;
  logic [1:0]     r_size;
  logic [WIN-1:0] r_win;

  logic [WIN-1:0] szmask;
  always_comb begin
    case (r_size)
      2'd0:    szmask = 64'h0000_0000_0000_00FF;
      2'd1:    szmask = 64'h0000_0000_0000_FFFF;
      2'd2:    szmask = 64'h0000_0000_FFFF_FFFF;
      default: szmask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      r_op   <= '0;
      r_len  <= 6'd32;
      r_bofs <= '0;
      r_ofs  <= '0;
      r_val  <= '0;
      r_addr <= '0;
      r_size <= '0;
      r_win  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          r_op   <= op;
          r_len  <= len_in;
          r_bofs <= p_bofs;
          r_ofs  <= bit_ofs;
          r_val  <= src_val;
          r_addr <= p_addr;
          r_size <= p_size;
          st     <= S_RD;
        end
        S_RD: if (mem_ack) begin
          r_win <= mem_rdata & szmask;
          st    <= writes(r_op) ? S_WR : S_FIN;
        end
        S_WR: if (mem_ack) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  // field datapath
  logic [6:0]     lsh;
  logic [WIN-1:0] fmask, ins_bits, lj, new_win;
  logic [31:0]    old_lj;

  assign lsh      = 7'd64 - {1'b0, r_len};
  assign fmask    = ({WIN{1'b1}} << lsh) >> r_bofs;
  assign ins_bits = ({32'd0, r_val} << lsh) >> r_bofs;
  assign lj       = (r_win & fmask) << r_bofs;
  assign old_lj   = lj[63:32];

  always_comb begin
    case (r_op)
      3'd2:    new_win = (r_win & ~fmask) | ins_bits;
      3'd3:    new_win = r_win ^ fmask;
      3'd4:    new_win = r_win & ~fmask;
      default: new_win = r_win | fmask;
    endcase
  end

  logic [63:0] ext_u, ext_s;
  assign ext_u = lj >> lsh;
  assign ext_s = $signed(lj) >>> lsh;

  always_comb begin
    case (r_op)
      3'd1:    result = ext_s[31:0];
      3'd2:    result = r_val << (6'd32 - r_len);
      3'd3, 3'd4, 3'd5: result = old_lj;
      3'd6:    result = r_ofs + ((old_lj != 32'd0) ? {26'd0, lead0(old_lj)} : {26'd0, r_len});
      default: result = ext_u[31:0];
    endcase
  end

  assign done      = (st == S_FIN);
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = r_addr;
  assign mem_size  = r_size;
  assign mem_wdata = new_win;

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  a_r9_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && writes(r_op) |=> mem_req && mem_we && $stable(mem_addr) && $stable(mem_size));

  a_r2_quad_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (mem_size == 2'd3) |-> (mem_addr[1:0] == 2'b00));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

// File: tb/sim_bitfield_mem_unit.sv
module sim_bitfield_mem_unit;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        start = 0;
  logic [2:0]  op = 0;
  logic [31:0] base_addr = 0, bit_ofs = 0, src_val = 0;
  logic [4:0]  width_code = 0;
  logic        done, mem_req, mem_we, mem_ack;
  logic [31:0] result, mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  bitfield_mem_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .base_addr(base_addr), .bit_ofs(bit_ofs), .width_code(width_code),
    .src_val(src_val), .done(done), .result(result), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  int compared = 0, mismatched = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, rd_prev = 0, wr_prev = 0;
  logic [7:0] dmem [64];
  logic [7:0] rmem [64];

  logic [31:0] q_res[$];
  int          q_wr[$];
  string       q_tag[$];

  // memory model, one cycle latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      automatic int n = 1 << mem_size;
      automatic logic [63:0] t = 0;
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int i = 0; i < n; i++)
          dmem[(mem_addr + i) & 63] <= mem_wdata[8*(n-1-i) +: 8];
        wr_cnt++;
      end else begin
        for (int i = 0; i < n; i++) t = (t << 8) | 64'(dmem[(mem_addr + i) & 63]);
        mem_rdata <= t;
        rd_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done && q_res.size() > 0) begin
      automatic logic [31:0] er = q_res.pop_front();
      automatic int ew = q_wr.pop_front();
      automatic string tg = q_tag.pop_front();
      automatic int bad = 0;
      check(result == er, tg, "result", result, er);
      check((wr_cnt - wr_prev) == ew && (rd_cnt - rd_prev) == 1, "R9", "writes", wr_cnt - wr_prev, ew);
      for (int i = 0; i < 64; i++) if (dmem[i] !== rmem[i]) bad++;
      check(bad == 0, "R3", "bytes differing in image", bad, 0);
      rd_prev = rd_cnt;
      wr_prev = wr_cnt;
    end
  end

  // reference model and driver
  task automatic run_cmd(input string tag, input logic [2:0] o, input int base,
                         input int ofs, input logic [4:0] wc, input logic [31:0] v,
                         input bit poke);
    int w = (wc == 0) ? 32 : int'(wc);
    longint abs0 = longint'(base) * 8 + longint'(ofs);
    logic [31:0] fld = 0, er;
    int first = -1;
    for (int k = 0; k < w; k++) begin
      longint p = abs0 + k;
      int bi = int'(p >>> 3) & 63;
      int bb = 7 - int'(p & 7);
      logic b = rmem[bi][bb];
      fld[w-1-k] = b;
      if (b && first < 0) first = k;
      case (o)
        3'd2: rmem[bi][bb] = v[w-1-k];
        3'd3: rmem[bi][bb] = ~b;
        3'd4: rmem[bi][bb] = 1'b0;
        3'd5: rmem[bi][bb] = 1'b1;
        default: ;
      endcase
    end
    case (o)
      3'd1: er = (fld[w-1] && w < 32) ? (fld | (32'hFFFF_FFFF << w)) : fld;
      3'd2: er = v << (32 - w);
      3'd3, 3'd4, 3'd5: er = fld << (32 - w);
      3'd6: er = 32'(ofs + ((first < 0) ? w : first));
      default: er = fld;
    endcase
    q_res.push_back(er);
    q_wr.push_back((o >= 2 && o <= 5) ? 1 : 0);
    q_tag.push_back(tag);
    @(negedge clk);
    op = o; base_addr = 32'(base); bit_ofs = 32'(ofs); width_code = wc; src_val = v;
    start = 1;
    @(negedge clk);
    if (poke) begin
      op = 3'd5; bit_ofs = 0; width_code = 0; base_addr = 32'(base);
      @(negedge clk);
      @(negedge clk);
    end
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dmem[i] = 8'((i * 37 + 11) & 255);
      rmem[i] = dmem[i];
    end
    repeat (3) @(negedge clk);
    check(done == 0 && mem_req == 0, "R11", "reset outputs", {done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(done == 0 && mem_req == 0, "R11", "idle after reset", {done, mem_req}, 0);

    run_cmd("R4",  3'd0, 20, 2, 5'd4, 0, 0);
    run_cmd("R4",  3'd7, 20, 5, 5'd9, 0, 0);
    run_cmd("R5",  3'd1, 30, 0, 5'd8, 0, 0);
    run_cmd("R5",  3'd1, 30, -13, 5'd11, 0, 0);
    run_cmd("R1",  3'd2, 21, 3, 5'd0, 32'hA5C3_0F96, 0);
    run_cmd("R1",  3'd0, 21, 3, 5'd0, 0, 0);
    run_cmd("R2",  3'd3, 23, 1, 5'd20, 0, 0);
    run_cmd("R2",  3'd0, 22, -27, 5'd31, 0, 0);
    run_cmd("R6",  3'd2, 40, 9, 5'd13, 32'hFFFF_1234, 0);
    run_cmd("R7",  3'd4, 33, 6, 5'd17, 0, 0);
    run_cmd("R8",  3'd6, 33, 6, 5'd17, 0, 0);
    run_cmd("R7",  3'd5, 33, 6, 5'd17, 0, 0);
    run_cmd("R8",  3'd6, 33, 6, 5'd17, 0, 0);
    run_cmd("R8",  3'd6, 27, -5, 5'd0, 0, 0);
    run_cmd("R10", 3'd0, 25, 4, 5'd6, 0, 1);
    run_cmd("R10", 3'd4, 26, 1, 5'd3, 0, 1);

    for (int n = 0; n < 400; n++) begin
      automatic logic [2:0] o = 3'($urandom_range(0, 7));
      automatic int b = int'($urandom_range(16, 47));
      automatic int f = int'($urandom_range(0, 200)) - 100;
      automatic logic [4:0] wc = 5'($urandom_range(0, 31));
      automatic logic [31:0] v = $urandom;
      run_cmd((o == 3'd1) ? "R5" : (o == 3'd6) ? "R8" : (o == 3'd2) ? "R6" : (o >= 3'd3 && o <= 3'd5) ? "R7" : "R4",
              o, b, f, wc, v, 0);
    end

    repeat (4) @(negedge clk);
    check(q_res.size() == 0, "R10", "pending results", q_res.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule